// File: doc/BRIEF.md
# Segmented Address Translation Checker

This unit turns a segment selector and an offset into a flat linear address and checks the access against a cached segment descriptor. The caller presents the operating mode, which segment register is being used, the selector, the offset and the cached descriptor fields together with a one-cycle request strobe. One clock later the unit returns three things: the flat address, the number of bytes that can still be reached from the offset, and a 2-bit status.

Every rule sits in one path: real and virtual-8086 segment arithmetic, flat-mode handling in 64-bit mode, 32-bit truncation in protected and compatibility mode, page-granular scaling of a raw limit, and the separate bound rules for normal, expand-down and system descriptors. When a check fails, the status reports the reason and the address and byte-count outputs are zero.

The control is a two-state machine. `S_IDLE` means no result is presented. `S_HOLD` means a result from the previous cycle is on the outputs. The transitions are:
- `go` (S_IDLE to S_HOLD) on `req_valid`.
- `again` (S_HOLD to S_HOLD) on `req_valid`.
- `drop` (S_HOLD to S_IDLE) when `req_valid` is low.
- `rest` (S_IDLE to S_IDLE) when `req_valid` is low.

Top module: `seg_xlate`

## Requirements
- R1: Results appear on the outputs with `out_valid_o` high exactly one cycle after `req_valid` is high. When `req_valid` is low, the next cycle has `out_valid_o` low and `flat_o`, `bytes_left_o` and `status_o` keep their values whatever the other inputs do. After reset all outputs are zero.
- R2: In real mode (`mode_i`=0) or virtual-8086 mode (`mode_i`=1), the flat address is offset[15:0] plus a base. The base is `base_i` when `base_valid_i` is 1; otherwise it is `selector_i` shifted left by 4. The status is always ok (00), whatever the descriptor fields hold.
- R3: In real or virtual-8086 mode, `bytes_left_o` equals 0x10000 minus offset[15:0].
- R4: In 64-bit mode (`mode_i`=4), the flat address is `base_i`+`offset_i` over the full 64 bits for FS (`seg_i`=4) and GS (`seg_i`=5). For every other segment it is `offset_i` alone. No limit check is made, and `bytes_left_o` is 0x1_0000_0000.
- R5: In protected mode (`mode_i`=2, and also the unused codes 5 to 7) and in compatibility mode (`mode_i`=3), the flat address is the low 32 bits of base[31:0]+offset[31:0], zero-extended. Offset bits above 31 are ignored.
- R6: When `limit_raw_i` is 1, `limit_i[19:0]` is a raw limit. With granularity set it becomes (raw<<12)|0xFFF; with granularity clear it is used as is. When `limit_raw_i` is 0, `limit_i` is the final limit.
- R7: For a normal code or data descriptor (`desc_s_i`=1, and not expand-down), an offset greater than the limit gives out of bounds (01). Otherwise `bytes_left_o` = limit - offset + 1, which is never above 0x1_0000_0000.
- R8: An expand-down descriptor has `desc_s_i`=1, type bit 3 clear and type bit 2 set. It gives out of bounds when the offset is at most the limit, or when granularity is clear and the offset is above 0xFFFF. Otherwise `bytes_left_o` = upper - offset + 1, where upper is 0xFFFFFFFF with granularity set and 0xFFFF with it clear.
- R9: A system descriptor (`desc_s_i`=0) with type 1, 2, 3, 4, 5, 6, 7, 9, 11, 12, 14 or 15 is checked like a normal one (offset > limit gives 01). On success, `bytes_left_o` = 0x1_0000_0000 minus the 32-bit flat address.
- R10: Outside real and virtual-8086 mode, `desc_present_i`=0 gives not present (11). This takes priority over the type and limit checks.
- R11: A present system descriptor with type 0, 8, 10 or 13 gives invalid selector (10). This applies in 64-bit mode too.
- R12: Whenever the status is not ok, `flat_o` and `bytes_left_o` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| mode_i | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| seg_i | input | 3 | Segment register: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| selector_i | input | 16 | Selector value |
| offset_i | input | 64 | Offset within the segment |
| base_i | input | 64 | Cached segment base |
| base_valid_i | input | 1 | Cached base is usable in real/virtual-8086 mode |
| limit_i | input | 32 | Final limit, or raw limit in bits 19:0 |
| limit_raw_i | input | 1 | Treat limit_i as a raw 20-bit limit |
| desc_present_i | input | 1 | Descriptor present |
| desc_s_i | input | 1 | 1 code/data descriptor, 0 system descriptor |
| desc_gran_i | input | 1 | Page granularity |
| desc_type_i | input | 4 | Descriptor type code |
| out_valid_o | output | 1 | Result valid (state S_HOLD) |
| flat_o | output | 64 | Flat linear address |
| bytes_left_o | output | 33 | Bytes reachable from the offset |
| status_o | output | 2 | 00 ok, 01 out of bounds, 10 invalid selector, 11 not present |

## Verification
In the expand-down path, two bound conditions can hold in the same cycle: the offset can be at or below the limit and also above the 16-bit ceiling when granularity is clear. The vectors place each condition alone and also put the lower bound exactly on the limit, and the status is judged against 01 in every case. A second overlap is the not-present fault together with an unrecognised system type in the same request; the bench provokes it with type 0 and a clear present bit and expects not present (11), never invalid selector. The result-hold behaviour and a fresh request can also meet on back-to-back strobes, and the table is walked with the strobe held high so that every result is judged on the very next cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        MD_REAL   = 3'd0,
        MD_V86    = 3'd1,
        MD_PROT   = 3'd2,
        MD_COMPAT = 3'd3,
        MD_LONG   = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'b00,
        ST_OOB    = 2'b01,
        ST_BADSEL = 2'b10,
        ST_ABSENT = 2'b11
    } status_e;

    // Check class derived from the descriptor-type bit and the type code
    typedef enum logic [1:0] {
        CL_FLAT = 2'd0,
        CL_DOWN = 2'd1,
        CL_SYS  = 2'd2,
        CL_BAD  = 2'd3
    } cls_e;

    // Bit n set: system type n is accepted
    localparam logic [15:0] SYS_OK_MASK = 16'hDAFE;

    localparam logic [2:0] SEG_FS = 3'd4;
    localparam logic [2:0] SEG_GS = 3'd5;

endpackage

// File: rtl/seg_xlate_limit.sv
module seg_xlate_limit #(
    parameter int LIM_W   = 32,
    parameter int RAW_W   = 20,
    parameter int PAGE_SH = 12
) (
    input  logic [LIM_W-1:0] lim_in,
    input  logic             raw_mode,
    input  logic             gran,
    output logic [LIM_W-1:0] lim_eff
);
    localparam int SCALED_W = RAW_W + PAGE_SH;

    logic [SCALED_W-1:0] scaled;
    logic [LIM_W-1:0]    plain;

    assign scaled = {lim_in[RAW_W-1:0], {PAGE_SH{1'b1}}};
    assign plain  = LIM_W'(lim_in[RAW_W-1:0]);

    always_comb begin
        if (!raw_mode)
            lim_eff = lim_in;
        else if (gran)
            lim_eff = LIM_W'(scaled);
        else
            lim_eff = plain;
    end
endmodule

// File: rtl/seg_xlate_class.sv
module seg_xlate_class
    import seg_xlate_pkg::*;
(
    input  logic       s_bit,
    input  logic [3:0] typ,
    output cls_e       cls
);
    always_comb begin
        if (s_bit) begin
            // data type with the expand-direction bit set
            if (!typ[3] && typ[2])
                cls = CL_DOWN;
            else
                cls = CL_FLAT;
        end else if (SYS_OK_MASK[typ]) begin
            cls = CL_SYS;
        end else begin
            cls = CL_BAD;
        end
    end
endmodule

// File: rtl/seg_xlate_addr.sv
module seg_xlate_addr
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int SEL_W = 16,
    parameter int NA_W  = 32
) (
    input  logic [2:0]       seg,
    input  logic [SEL_W-1:0] sel,
    input  logic [VA_W-1:0]  off,
    input  logic [VA_W-1:0]  base,
    input  logic             base_valid,
    output logic [VA_W-1:0]  flat_real,
    output logic [VA_W-1:0]  flat_long,
    output logic [NA_W-1:0]  flat_narrow
);
    logic [VA_W-1:0] real_base;

    assign real_base   = base_valid ? base : VA_W'({sel, 4'b0000});
    assign flat_real   = real_base + VA_W'(off[15:0]);
    assign flat_long   = (seg == SEG_FS || seg == SEG_GS) ? (base + off) : off;
    assign flat_narrow = base[NA_W-1:0] + off[NA_W-1:0];
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int SEL_W = 16,
    parameter int LIM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       mode_i,
    input  logic [2:0]       seg_i,
    input  logic [SEL_W-1:0] selector_i,
    input  logic [VA_W-1:0]  offset_i,
    input  logic [VA_W-1:0]  base_i,
    input  logic             base_valid_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             limit_raw_i,
    input  logic             desc_present_i,
    input  logic             desc_s_i,
    input  logic             desc_gran_i,
    input  logic [3:0]       desc_type_i,
    output logic             out_valid_o,
    output logic [VA_W-1:0]  flat_o,
    output logic [LIM_W:0]   bytes_left_o,
    output logic [1:0]       status_o
);
    localparam int BYTES_W = LIM_W + 1;
    localparam logic [BYTES_W-1:0] FULL_SPAN = {1'b1, {LIM_W{1'b0}}};
    localparam logic [BYTES_W-1:0] RM_SPAN   = BYTES_W'(32'h0001_0000);
    localparam logic [LIM_W-1:0]   SMALL_TOP = LIM_W'(32'h0000_FFFF);

    typedef enum logic {S_IDLE, S_HOLD} state_e;

    state_e state_q, state_d;

    logic [LIM_W-1:0]   lim_eff;
    cls_e               cls;
    logic [VA_W-1:0]    flat_real, flat_long;
    logic [LIM_W-1:0]   flat_narrow;
    logic [LIM_W-1:0]   off_n;
    logic [LIM_W-1:0]   upper;
    logic [BYTES_W-1:0] off_ext;
    logic               is_rm;

    logic [VA_W-1:0]    flat_d;
    logic [BYTES_W-1:0] bytes_d;
    status_e            st_d;

    seg_xlate_limit #(.LIM_W(LIM_W)) u_limit (
        .lim_in   (limit_i),
        .raw_mode (limit_raw_i),
        .gran     (desc_gran_i),
        .lim_eff  (lim_eff)
    );

    seg_xlate_class u_class (
        .s_bit (desc_s_i),
        .typ   (desc_type_i),
        .cls   (cls)
    );

    seg_xlate_addr #(.VA_W(VA_W), .SEL_W(SEL_W), .NA_W(LIM_W)) u_addr (
        .seg         (seg_i),
        .sel         (selector_i),
        .off         (offset_i),
        .base        (base_i),
        .base_valid  (base_valid_i),
        .flat_real   (flat_real),
        .flat_long   (flat_long),
        .flat_narrow (flat_narrow)
    );

    assign off_n   = offset_i[LIM_W-1:0];
    assign off_ext = {1'b0, off_n};
    assign is_rm   = (mode_i == MD_REAL) || (mode_i == MD_V86);
    assign upper   = desc_gran_i ? {LIM_W{1'b1}} : SMALL_TOP;

    // Translation and check result for the current request
    always_comb begin
        st_d    = ST_OK;
        flat_d  = '0;
        bytes_d = '0;
        if (is_rm) begin
            flat_d  = flat_real;
            bytes_d = RM_SPAN - BYTES_W'(offset_i[15:0]);
        end else if (!desc_present_i) begin
            st_d = ST_ABSENT;
        end else if (cls == CL_BAD) begin
            st_d = ST_BADSEL;
        end else if (mode_i == MD_LONG) begin
            flat_d  = flat_long;
            bytes_d = FULL_SPAN;
        end else begin
            unique case (cls)
                CL_FLAT, CL_SYS: begin
                    if (off_n > lim_eff) begin
                        st_d = ST_OOB;
                    end else begin
                        flat_d  = VA_W'(flat_narrow);
                        bytes_d = (cls == CL_SYS) ? (FULL_SPAN - {1'b0, flat_narrow})
                                                  : ({1'b0, lim_eff} - off_ext + 1'b1);
                    end
                end
                CL_DOWN: begin
                    if ((off_n <= lim_eff) || (!desc_gran_i && off_n > SMALL_TOP)) begin
                        st_d = ST_OOB;
                    end else begin
                        flat_d  = VA_W'(flat_narrow);
                        bytes_d = {1'b0, upper} - off_ext + 1'b1;
                    end
                end
                default: st_d = ST_BADSEL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: go / again on a strobe, drop / rest without one
    always_comb begin
        unique case (state_q)
            S_IDLE: state_d = req_valid ? S_HOLD : S_IDLE;
            S_HOLD: state_d = req_valid ? S_HOLD : S_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flat_o       <= '0;
            bytes_left_o <= '0;
            status_o     <= ST_OK;
        end else if (req_valid) begin
            flat_o       <= flat_d;
            bytes_left_o <= bytes_d;
            status_o     <= st_d;
        end
    end

    assign out_valid_o = (state_q == S_HOLD);

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  mode_i,
    input logic [63:0] offset_i,
    input logic        desc_present_i,
    input logic        out_valid_o,
    input logic [63:0] flat_o,
    input logic [32:0] bytes_left_o,
    input logic [1:0]  status_o
);
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid_o); // R1

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid_o && $stable(flat_o) && $stable(status_o))); // R1

    AST_RM_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_i <= 3'd1) |=> status_o == 2'b00); // R2

    AST_RM_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_i <= 3'd1) |=>
            bytes_left_o == (33'h0_0001_0000 - {17'b0, $past(offset_i[15:0])})); // R3

    AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_i >= 3'd2 && !desc_present_i) |=> status_o == 2'b11); // R10

    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && status_o != 2'b00) |-> (flat_o == 64'd0 && bytes_left_o == 33'd0)); // R12

    AST_SPAN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> bytes_left_o <= 33'h1_0000_0000); // R7
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .mode_i         (mode_i),
    .offset_i       (offset_i),
    .desc_present_i (desc_present_i),
    .out_valid_o    (out_valid_o),
    .flat_o         (flat_o),
    .bytes_left_o   (bytes_left_o),
    .status_o       (status_o)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

    typedef struct packed {
        logic [2:0]  mode;
        logic [2:0]  seg;
        logic [15:0] sel;
        logic [63:0] off;
        logic [63:0] base;
        logic        bval;
        logic [31:0] lim;
        logic        raw;
        logic        p;
        logic        s;
        logic        g;
        logic [3:0]  typ;
        logic [63:0] e_flat;
        logic [32:0] e_bytes;
        logic [1:0]  e_st;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R2: real mode, shifted selector, high offset bits masked
        '{3'd0, 3'd3, 16'h1234, 64'hFFFF_0010, 64'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0,
          64'h12350, 33'h0FFF0, 2'b00, 8'd2},
        // R3: v86 with cached base, last byte of the window, descriptor absent ignored
        '{3'd1, 3'd3, 16'h0040, 64'hFFFF, 64'h20000, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0,
          64'h2FFFF, 33'h1, 2'b00, 8'd3},
        // R3: offset zero gives the full 64 KiB window
        '{3'd0, 3'd1, 16'h0000, 64'h0, 64'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0,
          64'h0, 33'h10000, 2'b00, 8'd3},
        // R7 (and R5: offset bits above 31 ignored)
        '{3'd2, 3'd3, 16'h0, 64'hABCD_0000_0000_0100, 64'h1000_0000, 1'b0, 32'hFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2,
          64'h1000_0100, 33'hF00, 2'b00, 8'd7},
        // R7: offset equal to limit
        '{3'd2, 3'd3, 16'h0, 64'hFFF, 64'h1000_0000, 1'b0, 32'hFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2,
          64'h1000_0FFF, 33'h1, 2'b00, 8'd7},
        // R7: one past the limit
        '{3'd2, 3'd3, 16'h0, 64'h1000, 64'h1000_0000, 1'b0, 32'hFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2,
          64'h0, 33'h0, 2'b01, 8'd7},
        // R5: compatibility mode wrap at 32 bits, code segment
        '{3'd3, 3'd1, 16'h0, 64'h2000, 64'hFFFF_F000, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'hA,
          64'h1000, 33'hFFFF_E000, 2'b00, 8'd5},
        // R6: raw limit scaled by page granularity
        '{3'd2, 3'd3, 16'h0, 64'h1FFF, 64'h0, 1'b0, 32'h1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0,
          64'h1FFF, 33'h1, 2'b00, 8'd6},
        // R6: raw limit without granularity
        '{3'd2, 3'd3, 16'h0, 64'h2, 64'h0, 1'b0, 32'h1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0,
          64'h0, 33'h0, 2'b01, 8'd6},
        // R8: expand-down inside the valid window
        '{3'd2, 3'd2, 16'h0, 64'h1000, 64'h8000, 1'b0, 32'hFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'h6,
          64'h9000, 33'hF000, 2'b00, 8'd8},
        // R8: expand-down offset equal to limit
        '{3'd2, 3'd2, 16'h0, 64'hFFF, 64'h8000, 1'b0, 32'hFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'h6,
          64'h0, 33'h0, 2'b01, 8'd8},
        // R8: expand-down above the 16-bit ceiling
        '{3'd2, 3'd2, 16'h0, 64'h10000, 64'h8000, 1'b0, 32'hFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'h6,
          64'h0, 33'h0, 2'b01, 8'd8},
        // R8: expand-down with granularity set
        '{3'd2, 3'd2, 16'h0, 64'h10000, 64'h0, 1'b0, 32'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 4'h4,
          64'h10000, 33'hFFFF_0000, 2'b00, 8'd8},
        // R10: absent data descriptor
        '{3'd2, 3'd3, 16'h0, 64'h0, 64'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h2,
          64'h0, 33'h0, 2'b11, 8'd10},
        // R10: absent wins over an unknown system type
        '{3'd2, 3'd3, 16'h0, 64'h0, 64'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0,
          64'h0, 33'h0, 2'b11, 8'd10},
        // R11: unknown system type
        '{3'd2, 3'd3, 16'h0, 64'h0, 64'h0, 1'b0, 32'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'hD,
          64'h0, 33'h0, 2'b10, 8'd11},
        // R9: system descriptor in range
        '{3'd2, 3'd0, 16'h0, 64'h10, 64'hFFFF_FF00, 1'b0, 32'h67, 1'b0, 1'b1, 1'b0, 1'b0, 4'h9,
          64'hFFFF_FF10, 33'hF0, 2'b00, 8'd9},
        // R9: system descriptor past its limit
        '{3'd2, 3'd0, 16'h0, 64'h68, 64'h0, 1'b0, 32'h67, 1'b0, 1'b1, 1'b0, 1'b0, 4'hB,
          64'h0, 33'h0, 2'b01, 8'd9},
        // R4: 64-bit mode data segment, base ignored, no limit check
        '{3'd4, 3'd3, 16'h0, 64'h0000_7FFF_0000_1234, 64'h5000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2,
          64'h0000_7FFF_0000_1234, 33'h1_0000_0000, 2'b00, 8'd4},
        // R10: absent in 64-bit mode
        '{3'd4, 3'd3, 16'h0, 64'h10, 64'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h2,
          64'h0, 33'h0, 2'b11, 8'd10},
        // R4: 64-bit mode FS keeps its full base
        '{3'd4, 3'd4, 16'h0, 64'h20, 64'h0000_1000_0000_0000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2,
          64'h0000_1000_0000_0020, 33'h1_0000_0000, 2'b00, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  mode_i;
    logic [2:0]  seg_i;
    logic [15:0] selector_i;
    logic [63:0] offset_i;
    logic [63:0] base_i;
    logic        base_valid_i;
    logic [31:0] limit_i;
    logic        limit_raw_i;
    logic        desc_present_i;
    logic        desc_s_i;
    logic        desc_gran_i;
    logic [3:0]  desc_type_i;
    logic        out_valid_o;
    logic [63:0] flat_o;
    logic [32:0] bytes_left_o;
    logic [1:0]  status_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    seg_xlate dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .mode_i         (mode_i),
        .seg_i          (seg_i),
        .selector_i     (selector_i),
        .offset_i       (offset_i),
        .base_i         (base_i),
        .base_valid_i   (base_valid_i),
        .limit_i        (limit_i),
        .limit_raw_i    (limit_raw_i),
        .desc_present_i (desc_present_i),
        .desc_s_i       (desc_s_i),
        .desc_gran_i    (desc_gran_i),
        .desc_type_i    (desc_type_i),
        .out_valid_o    (out_valid_o),
        .flat_o         (flat_o),
        .bytes_left_o   (bytes_left_o),
        .status_o       (status_o)
    );

    task automatic check(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode_i         = v.mode;
        seg_i          = v.seg;
        selector_i     = v.sel;
        offset_i       = v.off;
        base_i         = v.base;
        base_valid_i   = v.bval;
        limit_i        = v.lim;
        limit_raw_i    = v.raw;
        desc_present_i = v.p;
        desc_s_i       = v.s;
        desc_gran_i    = v.g;
        desc_type_i    = v.typ;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        apply(VECS[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(1, "reset out_valid", 64'(out_valid_o), 64'd0);
        check(1, "reset flat", flat_o, 64'd0);
        check(1, "reset bytes", 64'(bytes_left_o), 64'd0);
        check(1, "reset status", 64'(status_o), 64'd0);

        // Table walk with the strobe held high (back-to-back requests)
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            check(1, "out_valid after strobe", 64'(out_valid_o), 64'd1);
            check(int'(VECS[i].rq), $sformatf("vec%0d status", i), 64'(status_o), 64'(VECS[i].e_st));
            check(int'(VECS[i].rq), $sformatf("vec%0d flat", i), flat_o, VECS[i].e_flat);
            check(int'(VECS[i].rq), $sformatf("vec%0d bytes", i), 64'(bytes_left_o), 64'(VECS[i].e_bytes));
        end

        // R1: without a strobe, inputs that would fault are ignored
        req_valid = 1'b0;
        apply(VECS[5]);
        @(negedge clk);
        check(1, "drop out_valid", 64'(out_valid_o), 64'd0);
        check(1, "hold flat", flat_o, VECS[NV-1].e_flat);
        check(1, "hold bytes", 64'(bytes_left_o), 64'(VECS[NV-1].e_bytes));
        check(1, "hold status", 64'(status_o), 64'(VECS[NV-1].e_st));

        // R1: single isolated strobe, one-cycle result, then idle again
        apply(VECS[9]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(1, "single strobe valid", 64'(out_valid_o), 64'd1);
        check(8, "single strobe flat", flat_o, 64'h9000);
        @(negedge clk);
        check(1, "single strobe drop", 64'(out_valid_o), 64'd0);
        check(8, "single strobe hold", flat_o, 64'h9000);

        // R1: reset in the middle clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, "mid reset flat", flat_o, 64'd0);
        check(1, "mid reset bytes", 64'(bytes_left_o), 64'd0);
        check(1, "mid reset valid", 64'(out_valid_o), 64'd0);

        finish_run();
    end

endmodule